// File: doc/BRIEF.md
# Solenoid Pull-In and Hold Gate Controller

This block drives the gate of a high-side load switch for a coil-type load. While the enable level is high, the gate is first held fully on for a programmable pull-in interval so that the armature can close. The block then falls back to a fixed-frequency pulse train at a lower hold duty, which saves power. A dedicated pull-in code keeps the gate fully on for as long as enable stays high, and no pulse train follows.

The pulse timebase is a counter that runs freely from reset and is never realigned to enable. The first hold pulse after pull-in can therefore be cut short. Several controllers can share one timebase. A unit in leader mode exports its gate drive on a sync output. A unit in follower mode ignores its own timing settings and copies its sync input, gated by enable. A fault-off input blocks the gate at once without disturbing the internal phase.

Top module: `solenoid_hold_ctrl`

## Requirements
- R1: While `enable` is low at a clock edge, `gate` is low in the following cycle. Enable acts on its level, not on its edges.
- R2: In leader mode (`master_sel`=1), enable high for N cycles with pull-in code P (P below all-ones) drives `gate` high for the first P+1 of those cycles. This holds whatever the hold duty is. Code 0 gives the minimum of one cycle.
- R3: The all-ones pull-in code keeps `gate` high for every cycle that enable stays high, and no pulse train follows.
- R4: During hold, each period lasts `period` cycles (0 behaves as 1). `gate` is high for the first floor(period*d/100) cycles of the period, where d is `duty` clamped to the range 10..90.
- R5: The period counter runs freely from reset and ignores enable. A new `period` or `duty` value is taken only when the current period ends.
- R6: In leader mode, `sync_out` equals the registered gate drive. It keeps following the pulse timing while `fault_off` blocks `gate`.
- R7: In follower mode (`master_sel`=0), `gate` equals `enable AND sync_in` from the previous edge. Pull-in and duty settings have no effect, and `sync_out` stays low.
- R8: `fault_off` high forces `gate` low in the same cycle. The pull-in timer and the period counter keep running, so when `fault_off` is released, `gate` resumes where the schedule has reached.
- R9: Every low level of enable clears the pull-in timer, so each new high level of enable starts a full pull-in.
- R10: While `rst_n` is low at a clock edge, `gate` and `sync_out` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Level enable for the load |
| period | input | PER_W | Hold period in clock cycles |
| duty | input | DUTY_W | Hold duty in percent, clamped to 10..90 |
| pull_len | input | PULL_W | Pull-in length code; all ones means continuous |
| master_sel | input | 1 | 1 selects leader mode, 0 selects follower mode |
| sync_in | input | 1 | Gate request from a leader, used in follower mode |
| fault_off | input | 1 | Forces the gate off immediately |
| gate | output | 1 | Gate drive for the high-side switch |
| sync_out | output | 1 | Exported gate drive in leader mode |

## Verification
Two interactions need the most care. The first is the end of pull-in, which can land anywhere inside a period of the free-running counter. The second is a fault that overlaps either pull-in or hold pulses. The bench sweeps pull-in codes, periods and out-of-range and in-range duties, toggles enable at changing phases, and raises and releases `fault_off` during pull-in and during hold. An arithmetic cycle model, kept in the bench, predicts `gate` and `sync_out` for every cycle, and each cycle is compared after the clock edge.

// File: rtl/solhold_pkg.sv
// Shared constants and types for the pull-in/hold gate controller.
// Assumes: duty is given in whole percent.
package solhold_pkg;
    localparam int MIN_PCT = 10;
    localparam int MAX_PCT = 90;

    // Phase of the leader-mode gate schedule.
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_PULL = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;
endpackage

// File: rtl/hold_period_gen.sv
// Free-running hold timebase. It counts 0..per_q-1, and at the end of each
// period it latches a new period length and on-time. pwm_on is high for
// the first on_q cycles of each period.
// Assumes: DUTY_W >= 7 so that the percent limits fit.
module hold_period_gen #(
    parameter int PER_W  = 8,
    parameter int DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_on
);
    import solhold_pkg::*;

    localparam int PROD_W = PER_W + DUTY_W;

    logic [PER_W-1:0]  cnt_q, per_q, on_q;
    logic [DUTY_W-1:0] pct;
    logic [PROD_W-1:0] prod;
    logic [PER_W-1:0]  on_next;
    logic              wrap;

    // Clamp the requested duty into the permitted window.
    always_comb begin
        if (duty_i < DUTY_W'(MIN_PCT))      pct = DUTY_W'(MIN_PCT);
        else if (duty_i > DUTY_W'(MAX_PCT)) pct = DUTY_W'(MAX_PCT);
        else                                pct = duty_i;
    end

    // On-time in cycles, rounded down.
    always_comb begin
        prod    = PROD_W'(period_i) * PROD_W'(pct);
        on_next = PER_W'(prod / PROD_W'(100));
    end

    // End of the current period.
    assign wrap = ({1'b0, cnt_q} + (PER_W+1)'(1)) >= {1'b0, per_q};

    // Counter advance and settings latched at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
            on_q  <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
            per_q <= period_i;
            on_q  <= on_next;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    assign pwm_on = cnt_q < on_q;

    // R5: settings change only at a period boundary.
    a_r5_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(on_q) && $stable(per_q)));
    // R5: the counter stays inside the latched period.
    a_r5_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q != '0) |-> (cnt_q < per_q));
    // R4: the on-time lies between 10 % and 90 % of the period.
    a_r4_on_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(on_q) * 100 <= int'(per_q) * MAX_PCT) &&
         (int'(on_q) * 100 + 100 > int'(per_q) * MIN_PCT)));
endmodule

// File: rtl/pullin_timer.sv
// Pull-in timer. It counts the cycles for which enable has been high and
// flags the full-on interval (pull_len+1 cycles). The all-ones code means
// continuous full-on. The timer is cleared while enable is low.
// Assumes: pull_len is held steady during a pull-in.
module pullin_timer #(
    parameter int PULL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PULL_W-1:0] pull_len,
    output logic              in_pull
);
    localparam logic [PULL_W-1:0] INF_CODE = '1;

    logic [PULL_W-1:0] cnt_q;
    logic              infinite;

    assign infinite = (pull_len == INF_CODE);
    assign in_pull  = infinite || (cnt_q <= pull_len);

    // Count the enabled cycles, saturating once pull-in is over.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cnt_q <= '0;
        else if (!infinite && (cnt_q <= pull_len))
            cnt_q <= cnt_q + PULL_W'(1);
    end

    // R9: the first enabled cycle after a low level is always pull-in.
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !$past(enable)) |-> in_pull);
endmodule

// File: rtl/solenoid_hold_ctrl.sv
// Top of the pull-in/hold gate controller. In leader mode it combines the
// pull-in timer and the hold timebase into a registered gate drive, and it
// exports that drive on sync_out. In follower mode it registers
// enable AND sync_in. fault_off masks the gate output combinationally.
// Assumes: sync_in is synchronous to clk.
module solenoid_hold_ctrl #(
    parameter int PER_W  = 8,
    parameter int DUTY_W = 7,
    parameter int PULL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PER_W-1:0]  period,
    input  logic [DUTY_W-1:0] duty,
    input  logic [PULL_W-1:0] pull_len,
    input  logic              master_sel,
    input  logic              sync_in,
    input  logic              fault_off,
    output logic              gate,
    output logic              sync_out
);
    import solhold_pkg::*;

    logic   in_pull, pwm_on, drive_q, drive_d;
    phase_e phase;

    hold_period_gen #(.PER_W(PER_W), .DUTY_W(DUTY_W)) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .period_i(period),
        .duty_i  (duty),
        .pwm_on  (pwm_on)
    );

    pullin_timer #(.PULL_W(PULL_W)) u_pull (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .pull_len(pull_len),
        .in_pull (in_pull)
    );

    // Decode the leader-mode phase.
    always_comb begin
        if (!enable)      phase = PH_OFF;
        else if (in_pull) phase = PH_PULL;
        else              phase = PH_HOLD;
    end

    // Select the next drive level for the current mode and phase.
    always_comb begin
        if (!master_sel) drive_d = enable && sync_in;
        else begin
            unique case (phase)
                PH_PULL: drive_d = 1'b1;
                PH_HOLD: drive_d = pwm_on;
                default: drive_d = 1'b0;
            endcase
        end
    end

    // Register the drive level.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= drive_d;
    end

    assign gate     = drive_q && !fault_off;
    assign sync_out = master_sel && drive_q;

    // R1: a low enable turns the gate off at the next edge.
    a_r1_off_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate);
    // R7: a follower passes a requested pulse through one cycle later.
    a_r7_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && enable && sync_in) |=> (gate || fault_off));
    // R6: in leader mode the gate is never on without sync_out.
    a_r6_sync_covers_gate: assert property (@(posedge clk) disable iff (!rst_n)
        master_sel |-> (sync_out || !gate));
endmodule

// File: tb/solenoid_hold_ctrl_test.sv
// Self-checking bench with an arithmetic per-cycle model of gate and sync_out.
module solenoid_hold_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] period = 8'd0;
    logic [6:0] duty = 7'd0;
    logic [7:0] pull_len = 8'd0;
    logic       master_sel = 1'b1;
    logic       sync_in = 1'b0;
    logic       fault_off = 1'b0;
    logic       gate, sync_out;

    int vectors = 0, fails = 0;
    int m_cnt = 0, m_per = 0, m_on = 0, m_pin = 0, m_drive = 0;

    always #2 clk = ~clk;

    solenoid_hold_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .duty(duty), .pull_len(pull_len), .master_sel(master_sel),
        .sync_in(sync_in), .fault_off(fault_off), .gate(gate),
        .sync_out(sync_out)
    );

    function automatic int clampd(int d);
        if (d < 10) return 10;
        if (d > 90) return 90;
        return d;
    endfunction

    // One clock: predict, advance, compare after the edge, return at negedge.
    task automatic step(string tag);
        int nd, inpull, pwm, eg, es;
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_on = 0; m_pin = 0; nd = 0;
        end else begin
            pwm    = (m_cnt < m_on);
            inpull = (pull_len == 8'hFF) || (m_pin <= int'(pull_len));
            nd = enable && (master_sel ? (inpull || pwm) : sync_in);
            if (!enable) m_pin = 0;
            else if (pull_len != 8'hFF && m_pin <= int'(pull_len)) m_pin++;
            if (m_cnt + 1 >= m_per) begin
                m_cnt = 0; m_per = period;
                m_on = (int'(period) * clampd(duty)) / 100;
            end else m_cnt++;
        end
        @(posedge clk); #1;
        m_drive = nd;
        eg = m_drive && !fault_off;
        es = master_sel && m_drive;
        vectors++;
        if (gate !== eg[0] || sync_out !== es[0]) begin
            fails++;
            $display("FAIL %s: gate=%b sync_out=%b expected gate=%0d sync_out=%0d",
                     tag, gate, sync_out, eg, es);
        end
        @(negedge clk);
    endtask

    task automatic run(int n, string tag);
        repeat (n) step(tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int pulls[3]  = '{0, 3, 255};
        int pers[4]   = '{1, 7, 10, 16};
        int duts[9]   = '{0, 5, 10, 33, 50, 77, 90, 95, 127};
        @(negedge clk);
        run(3, "R10");              // reset state
        rst_n = 1'b1;
        // R4 / R3 / R1 sweep in leader mode
        foreach (pulls[p]) foreach (pers[q]) foreach (duts[d]) begin
            pull_len = 8'(pulls[p]); period = 8'(pers[q]); duty = 7'(duts[d]);
            enable = 1'b1;
            run(30, (pulls[p] == 255) ? "R3" : "R4");
            enable = 1'b0;
            run(3, "R1");
        end
        // R2: pull-in length
        pull_len = 8'd6; period = 8'd10; duty = 7'd50; enable = 1'b1;
        run(20, "R2");
        // R5: changes in the middle of a period
        run(3, "R5"); duty = 7'd20; run(25, "R5");
        period = 8'd13; run(30, "R5");
        // R9: enable retriggers pull-in
        for (int k = 1; k <= 5; k++) begin
            enable = 1'b0; run(k, "R9");
            enable = 1'b1; run(k + 2, "R9");
        end
        // R8: fault during hold and during pull-in
        run(10, "R8");
        fault_off = 1'b1; run(4, "R8"); fault_off = 1'b0; run(6, "R8");
        enable = 1'b0; run(2, "R8");
        pull_len = 8'd8; enable = 1'b1; run(2, "R8");
        fault_off = 1'b1; run(3, "R8"); fault_off = 1'b0; run(12, "R8");
        // R6: sync_out keeps the pulse timing while the fault blocks the gate
        fault_off = 1'b1; run(20, "R6"); fault_off = 1'b0; run(4, "R6");
        // R7: follower mode
        master_sel = 1'b0;
        for (int i = 0; i < 40; i++) begin
            sync_in = (i % 3 == 0) || (i % 7 > 4);
            run(1, "R7");
        end
        enable = 1'b0; sync_in = 1'b1; run(3, "R7");
        enable = 1'b1; pull_len = 8'hFF; duty = 7'd0;
        for (int i = 0; i < 30; i++) begin
            sync_in = (i % 4 < 2);
            if (i == 12) fault_off = 1'b1;
            if (i == 15) fault_off = 1'b0;
            run(1, "R7");
        end
        summary();
        $finish;
    end
endmodule